// File: doc/BRIEF.md
# Sliding-Window Decoder Run Controller

This block sequences a sliding-window trellis decoder through its phases. In the accumulation phase it consumes one trellis stage per cycle in which branch metrics are offered. In the traceback phase it produces one decision per cycle. It does the stage bookkeeping against a frame length F, a reliability length R and a convergence length C, which are captured when a run starts. The first window accumulates R+C stages, capped at F. Each later window adds R stages, and its traceback releases R decisions. The final traceback releases whatever decisions are still owed, so that F decisions come out in total.

The host starts and steers runs with one-cycle commands and reads a two-bit status. A run started in stepping mode stops before every traceback, so the host can inspect the datapath. It is then advanced window by window, or released to finish the frame. A debug-halt input, qualified by a two-bit emulation control field, can freeze a run at a traceback boundary or at the end of the frame. A one-cycle interrupt marks each command pause and each completed frame. Commands that do not fit the current state are dropped, and each one sets a sticky error flag.

Top module: `swdec_run_ctrl`

## Requirements
- R1: After reset, status is 0 (idle), and `acc_en`, `tb_en`, `irq` and `err_flag` are all low.
- R2: Command code 1 (full run), accepted in idle or done, decodes the whole frame with no pause. Traceback bursts (runs of consecutive `tb_en` cycles) have length R, except the final one. Status is 1 (running) until the last decision and 3 (done) afterwards.
- R3: Command code 2 (stepping run), accepted in idle or done, accumulates min(R+C, F) stages. Status then becomes 2 (paused) before any traceback cycle, and no stage is consumed while paused.
- R4: A stage is consumed only in a cycle where `bm_valid` is high during accumulation. Each consumed stage gives a one-cycle `acc_en` pulse in the following cycle.
- R5: Command code 3 (step on), accepted only while paused by command, runs one traceback burst of R decisions. It then accumulates up to R further stages (capped at F) and pauses again.
- R6: The final traceback burst emits exactly F minus the decisions already emitted, so every frame yields exactly F `tb_en` cycles, even when F < R+C.
- R7: Command code 4 (finish), accepted only while paused by command, completes all remaining windows with no further pause and ends in status 3.
- R8: A command in a state that does not accept it, or a code outside 1..4, changes nothing in the run and sets `err_flag`. The flag then stays high until reset.
- R9: `irq` pulses for exactly one cycle on each entry to the command pause and on each entry to done. It does not pulse when the run stops for an emulation halt.
- R10: With `emu_ctrl[0]` (free) = 1, `dbg_halt` has no effect.
- R11: With free = 0 and `emu_ctrl[1]` (soft) = 0, a high `dbg_halt` stops the run at the next traceback boundary, before the traceback. Status is 2 until `dbg_halt` falls, and then the run continues.
- R12: With free = 0 and soft = 1, a high `dbg_halt` lets all tracebacks finish but holds the run in status 2 instead of done. The run enters done, with `irq`, once `dbg_halt` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | Command: 1 full run, 2 stepping run, 3 step on, 4 finish |
| frame_len | input | LW | Frame length F in stages, captured at start (F >= 1) |
| rel_len | input | LW | Reliability length R, captured at start (R >= 1) |
| conv_len | input | LW | Convergence length C, captured at start |
| emu_ctrl | input | 2 | Bit 1 soft, bit 0 free |
| dbg_halt | input | 1 | Host debug-halt request |
| bm_valid | input | 1 | Branch metrics for one stage available |
| acc_en | output | 1 | Accumulation strobe, one per consumed stage |
| tb_en | output | 1 | Traceback strobe, one per emitted decision |
| status | output | 2 | 0 idle, 1 running, 2 paused, 3 done |
| err_flag | output | 1 | Sticky bad-command flag |
| irq | output | 1 | One-cycle pulse on entry to pause or done |

## Verification
The bench goes after window arithmetic that is off by one, which would show as a first window of R+C±1 stages or as bursts one decision short or long. It also covers a final window that is not a whole R, and a frame shorter than R+C. A wrong controller there would emit R decisions instead of the leftover, or hang waiting for stages that never come. Metric gaps are checked with `bm_valid` held low and toggled, where a design that counts cycles instead of valid stages would pause early. A resume or start sent in mid-run must not restart the counters. Each emulation mode is checked to stop at its own boundary, which catches a swap of the soft and free bits and an interrupt raised on an emulation halt.

// File: rtl/swdec_pkg.sv
package swdec_pkg;
  localparam logic [2:0] CMD_RUN    = 3'd1;
  localparam logic [2:0] CMD_STEP   = 3'd2;
  localparam logic [2:0] CMD_NEXT   = 3'd3;
  localparam logic [2:0] CMD_FINISH = 3'd4;

  localparam logic [1:0] STAT_IDLE   = 2'd0;
  localparam logic [1:0] STAT_RUN    = 2'd1;
  localparam logic [1:0] STAT_PAUSED = 2'd2;
  localparam logic [1:0] STAT_DONE   = 2'd3;

  typedef enum logic [2:0] {
    F_IDLE, F_ACC, F_TB, F_HOLD, F_EMU, F_DONE
  } fsm_t;
endpackage

// File: rtl/swdec_stage_ctr.sv
module swdec_stage_ctr #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          advance,
  input  logic          step,
  input  logic [LW-1:0] flen,
  input  logic [LW-1:0] rlen,
  input  logic [LW-1:0] clen,
  output logic [LW-1:0] acc_cnt,
  output logic [LW-1:0] target,
  output logic          hit
);
  localparam int XW = LW + 1;

  logic [XW-1:0] first_sum, next_sum, f_ext;

  always_comb begin
    f_ext     = {1'b0, flen};
    first_sum = {1'b0, rlen} + {1'b0, clen};
    next_sum  = {1'b0, target} + {1'b0, rlen};
    hit       = step && ((acc_cnt + 1'b1) == target);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cnt <= '0;
      target  <= '0;
    end else if (init) begin
      acc_cnt <= '0;
      target  <= (first_sum < f_ext) ? first_sum[LW-1:0] : flen;
    end else begin
      if (step)    acc_cnt <= acc_cnt + 1'b1;
      if (advance) target  <= (next_sum < f_ext) ? next_sum[LW-1:0] : flen;
    end
  end

  // R3: accumulation never runs past the current window end
  a_r3_acc_in_window: assert property (@(posedge clk) disable iff (rst)
    acc_cnt <= target);
endmodule

// File: rtl/swdec_tb_ctr.sv
module swdec_tb_ctr #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          load,
  input  logic [LW-1:0] count,
  input  logic          step,
  output logic [LW-1:0] dec_cnt,
  output logic          last
);
  logic [LW-1:0] left;

  assign last = (left == {{(LW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      left    <= '0;
      dec_cnt <= '0;
    end else begin
      if (load)      left <= count;
      else if (step) left <= left - 1'b1;
      if (init)      dec_cnt <= '0;
      else if (step) dec_cnt <= dec_cnt + 1'b1;
    end
  end

  // R6: a traceback cycle always has a decision left to emit
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    step |-> (left != '0));
endmodule

// File: rtl/swdec_run_ctrl.sv
module swdec_run_ctrl
  import swdec_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [LW-1:0] frame_len,
  input  logic [LW-1:0] rel_len,
  input  logic [LW-1:0] conv_len,
  input  logic [1:0]    emu_ctrl,
  input  logic          dbg_halt,
  input  logic          bm_valid,
  output logic          acc_en,
  output logic          tb_en,
  output logic [1:0]    status,
  output logic          err_flag,
  output logic          irq
);
  fsm_t st, nx;
  logic [LW-1:0] f_q, r_q, c_q, acc_cnt, target, dec_cnt, tb_n;
  logic [LW-1:0] sel_f, sel_r, sel_c;
  logic pause_mode, emu_ret;
  logic start_ok, resume_ok, cmd_bad, step, hit, init, advance, tb_load, tb_last;
  logic final_win, emu_tb, emu_fr, emu_hold, irq_nx;

  swdec_stage_ctr #(.LW(LW)) u_stage (
    .clk(clk), .rst(rst), .init(init), .advance(advance), .step(step),
    .flen(sel_f), .rlen(sel_r), .clen(sel_c),
    .acc_cnt(acc_cnt), .target(target), .hit(hit));

  swdec_tb_ctr #(.LW(LW)) u_tb (
    .clk(clk), .rst(rst), .init(init), .load(tb_load), .count(tb_n),
    .step(tb_en), .dec_cnt(dec_cnt), .last(tb_last));

  always_comb begin
    start_ok  = cmd_valid && (cmd_code == CMD_RUN || cmd_code == CMD_STEP) &&
                (st == F_IDLE || st == F_DONE);
    resume_ok = cmd_valid && (cmd_code == CMD_NEXT || cmd_code == CMD_FINISH) &&
                (st == F_HOLD);
    cmd_bad   = cmd_valid && !start_ok && !resume_ok;
    init      = start_ok;
    sel_f     = init ? frame_len : f_q;
    sel_r     = init ? rel_len   : r_q;
    sel_c     = init ? conv_len  : c_q;
    step      = (st == F_ACC) && bm_valid;
    final_win = (target == f_q);
    tb_n      = final_win ? (f_q - dec_cnt) : r_q;
    emu_hold  = dbg_halt && !emu_ctrl[0];
    emu_tb    = emu_hold && !emu_ctrl[1];
    emu_fr    = emu_hold && emu_ctrl[1];
    tb_en     = (st == F_TB);
    nx = st; tb_load = 1'b0; advance = 1'b0; irq_nx = 1'b0;
    case (st)
      F_IDLE, F_DONE: if (start_ok) nx = F_ACC;
      F_ACC: if (hit) begin
        if (pause_mode)  begin nx = F_HOLD; irq_nx = 1'b1; end
        else if (emu_tb) nx = F_EMU;
        else begin nx = F_TB; tb_load = 1'b1; end
      end
      F_TB: if (tb_last) begin
        if (!final_win) begin nx = F_ACC; advance = 1'b1; end
        else if (emu_fr) nx = F_EMU;
        else begin nx = F_DONE; irq_nx = 1'b1; end
      end
      F_HOLD: if (resume_ok) begin nx = F_TB; tb_load = 1'b1; end
      F_EMU: if (!emu_hold) begin
        if (emu_ret) begin nx = F_DONE; irq_nx = 1'b1; end
        else begin nx = F_TB; tb_load = 1'b1; end
      end
      default: nx = F_IDLE;
    endcase
    case (st)
      F_ACC, F_TB:    status = STAT_RUN;
      F_HOLD, F_EMU:  status = STAT_PAUSED;
      F_DONE:         status = STAT_DONE;
      default:        status = STAT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= F_IDLE; f_q <= '0; r_q <= '0; c_q <= '0;
      pause_mode <= 1'b0; emu_ret <= 1'b0;
      err_flag <= 1'b0; irq <= 1'b0; acc_en <= 1'b0;
    end else begin
      st     <= nx;
      irq    <= irq_nx;
      acc_en <= step;
      if (cmd_bad) err_flag <= 1'b1;
      if (init) begin
        f_q <= frame_len; r_q <= rel_len; c_q <= conv_len;
        pause_mode <= (cmd_code == CMD_STEP);
      end
      if (resume_ok && cmd_code == CMD_FINISH) pause_mode <= 1'b0;
      if (nx == F_EMU && st != F_EMU) emu_ret <= (st == F_TB);
    end
  end

  // R4: every accumulation strobe traces back to an offered stage
  a_r4_bm_gate: assert property (@(posedge clk) disable iff (rst)
    acc_en |-> $past(bm_valid));
  // R3: nothing is consumed or emitted once a pause has settled
  a_r3_pause_quiet: assert property (@(posedge clk) disable iff (rst)
    (status == STAT_PAUSED && $past(status) == STAT_PAUSED) |-> (!acc_en && !tb_en));
  // R9: interrupt is a single-cycle pulse
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R8: error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  // R6: decisions never exceed the frame length
  a_r6_dec_bound: assert property (@(posedge clk) disable iff (rst)
    dec_cnt <= f_q);
endmodule

// File: tb/swdec_run_ctrl_test.sv
module swdec_run_ctrl_test;
  localparam int LW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cmd_valid, dbg_halt, bm_valid;
  logic [2:0] cmd_code;
  logic [LW-1:0] frame_len, rel_len, conv_len;
  logic [1:0] emu_ctrl;
  logic acc_en, tb_en, err_flag, irq;
  logic [1:0] status;

  swdec_run_ctrl #(.LW(LW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .frame_len(frame_len), .rel_len(rel_len), .conv_len(conv_len),
    .emu_ctrl(emu_ctrl), .dbg_halt(dbg_halt), .bm_valid(bm_valid),
    .acc_en(acc_en), .tb_en(tb_en), .status(status), .err_flag(err_flag), .irq(irq));

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];
  int burst = 0, acc_seen = 0, tb_seen = 0, irq_seen = 0, pause_seen = 0;
  int a0, t0, i0, p0;

  // monitor: pops the expected burst length whenever a traceback burst ends
  always @(negedge clk) begin
    cyc++;
    if (acc_en) acc_seen++;
    if (irq) irq_seen++;
    if (status == 2'd2) pause_seen++;
    if (tb_en) begin
      burst++; tb_seen++;
    end else if (burst > 0) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6: burst of %0d decisions, expected no burst", burst);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != burst) begin
          errors++;
          $display("FAIL R6: burst of %0d decisions, expected %0d", burst, e);
        end
      end
      burst = 0;
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic send(input int code);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = 3'(code);
    @(negedge clk); cmd_valid = 1'b0; cmd_code = 3'd0;
  endtask

  task automatic wait_stat(input int s, input string req);
    int n = 0;
    while (status != 2'(s) && n < 2000) begin @(negedge clk); n++; end
    check(req, int'(status), s);
  endtask

  task automatic setup(input int f, input int r, input int c);
    frame_len = LW'(f); rel_len = LW'(r); conv_len = LW'(c);
    a0 = acc_seen; t0 = tb_seen; i0 = irq_seen; p0 = pause_seen;
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_code = 3'd0; dbg_halt = 1'b0;
    bm_valid = 1'b0; emu_ctrl = 2'b00;
    frame_len = '0; rel_len = '0; conv_len = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1 status", int'(status), 0);
    check("R1 outputs", int'({acc_en, tb_en, irq, err_flag}), 0);

    // R2: full run, F=10 R=4 C=3 -> bursts 4 then 6
    setup(10, 4, 3); bm_valid = 1'b1;
    exp_q.push_back(4); exp_q.push_back(6);
    send(1);
    wait_stat(3, "R2 done");
    settle();
    check("R2 stages", acc_seen - a0, 10);
    check("R2 no pause", pause_seen - p0, 0);
    check("R9 done irq", irq_seen - i0, 1);
    check("R2 bursts seen", exp_q.size(), 0);

    // R3/R5: stepping run, F=10 R=4 C=3
    setup(10, 4, 3);
    send(2);
    wait_stat(2, "R3 paused");
    settle();
    check("R3 first window", acc_seen - a0, 7);
    check("R3 no traceback", tb_seen - t0, 0);
    check("R9 pause irq", irq_seen - i0, 1);
    repeat (10) @(negedge clk); #1;
    check("R3 held", acc_seen - a0, 7);
    exp_q.push_back(4);
    send(3);
    wait_stat(2, "R5 paused again");
    settle();
    check("R5 stages", acc_seen - a0, 10);
    check("R5 decisions", tb_seen - t0, 4);
    check("R9 second pause irq", irq_seen - i0, 2);
    exp_q.push_back(6);
    send(3);
    wait_stat(3, "R6 done");
    settle();
    check("R6 total decisions", tb_seen - t0, 10);
    check("R9 irq count", irq_seen - i0, 3);

    // R4/R7: gated metrics, then finish; F=19 R=4 C=2
    setup(19, 4, 2); bm_valid = 1'b0;
    send(2);
    repeat (20) @(negedge clk); #1;
    check("R4 no stage without metrics", acc_seen - a0, 0);
    check("R4 still running", int'(status), 1);
    for (int i = 0; i < 10; i++) begin @(negedge clk); bm_valid = (i % 2 == 0); end
    bm_valid = 1'b0;
    settle();
    check("R4 gated stages", acc_seen - a0, 5);
    check("R4 running", int'(status), 1);
    bm_valid = 1'b1;
    wait_stat(2, "R3 pause after gaps");
    settle();
    check("R4 window", acc_seen - a0, 6);
    exp_q.push_back(4); exp_q.push_back(4); exp_q.push_back(4);
    exp_q.push_back(4); exp_q.push_back(3);
    send(4);
    p0 = pause_seen;
    wait_stat(3, "R7 done");
    settle();
    check("R7 no further pause", pause_seen - p0, 0);
    check("R6 leftover total", tb_seen - t0, 19);
    check("R7 bursts seen", exp_q.size(), 0);

    // R8: misplaced and unknown commands
    check("R8 clear before", int'(err_flag), 0);
    setup(10, 4, 3); bm_valid = 1'b0;
    send(1);
    send(3);
    settle();
    check("R8 flag set", int'(err_flag), 1);
    check("R8 still running", int'(status), 1);
    send(1);
    send(7);
    settle();
    check("R8 running after bad start", int'(status), 1);
    exp_q.push_back(4); exp_q.push_back(6);
    bm_valid = 1'b1;
    wait_stat(3, "R8 run completes");
    settle();
    check("R8 no restart", acc_seen - a0, 10);
    check("R8 sticky", int'(err_flag), 1);

    // R10: free set, halt ignored
    setup(10, 4, 3); emu_ctrl = 2'b01; dbg_halt = 1'b1;
    exp_q.push_back(4); exp_q.push_back(6);
    send(1);
    wait_stat(3, "R10 done");
    settle();
    check("R10 no stop", pause_seen - p0, 0);

    // R11: stop at traceback boundary
    setup(10, 4, 3); emu_ctrl = 2'b00;
    exp_q.push_back(4); exp_q.push_back(6);
    send(1);
    wait_stat(2, "R11 halted");
    settle();
    check("R11 stages", acc_seen - a0, 7);
    check("R11 no traceback", tb_seen - t0, 0);
    check("R9 no irq on halt", irq_seen - i0, 0);
    repeat (10) @(negedge clk); #1;
    check("R11 stays halted", int'(status), 2);
    dbg_halt = 1'b0;
    wait_stat(3, "R11 resumes");
    settle();
    check("R11 done irq", irq_seen - i0, 1);

    // R12: stop at frame end
    setup(10, 4, 3); emu_ctrl = 2'b10; dbg_halt = 1'b1;
    exp_q.push_back(4); exp_q.push_back(6);
    send(1);
    wait_stat(2, "R12 halted");
    settle();
    check("R12 all decisions", tb_seen - t0, 10);
    check("R12 no irq yet", irq_seen - i0, 0);
    dbg_halt = 1'b0;
    wait_stat(3, "R12 done");
    settle();
    check("R12 irq", irq_seen - i0, 1);

    // R6: frame shorter than R+C
    setup(3, 4, 3); emu_ctrl = 2'b00;
    exp_q.push_back(3);
    send(1);
    wait_stat(3, "R6 short done");
    settle();
    check("R6 short stages", acc_seen - a0, 3);
    check("R6 short decisions", tb_seen - t0, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule